// File: doc/BRIEF.md
# DMA Bus Handoff Controller

This block hands the system bus back and forth between a processor and a DMA controller when the processor uses one shared, bidirectional request/grant wire. Each handoff event on that wire is a single active-low clock pulse. When the DMA controller raises its request, the block drives a one-clock low pulse on the wire to ask the processor to give up the bus. It then stops driving and listens. When the processor answers with its own one-clock low pulse, the block raises hold-acknowledge so that the DMA controller can start its transfers.

When the DMA controller lowers its request, the block drops hold-acknowledge. In the same clock it drives a second low pulse on the wire, which hands the bus back to the processor. A short recovery interval follows. During release and recovery, a new request is not acted on until the block is idle again. The wire itself is modelled as a separate sampled input, a drive value and an output enable, so a pad cell or the chip top can build the tri-state.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While rst_n is low, and afterwards until a request arrives, rqgt_oe is 0, rqgt_out is 1, hold_ack is 0 and dma_active is 0.
- R2: When dma_req_i is high in a clock where the block is idle, the next cycle has rqgt_oe=1 with rqgt_out=0 for exactly one cycle (the bus request pulse).
- R3: hold_ack rises in the cycle after the clock edge at which rqgt_in was sampled low while the block waited for a grant. It never rises otherwise.
- R4: A low level on rqgt_in while the block is idle or holding the bus has no effect on any output.
- R5: When dma_req_i is low at a clock edge while hold_ack is high, the next cycle has hold_ack=0 together with a one-cycle release pulse (rqgt_oe=1, rqgt_out=0).
- R6: After the release pulse the wire stays undriven for RECOVER_CYCLES cycles (default 1) with dma_active still high. Then the block is idle.
- R7: A request that is high during the release or recovery cycles starts no pulse before the block is idle. Its request pulse comes in the cycle after the first idle cycle.
- R8: dma_active is high from the request pulse through the last recovery cycle, and low otherwise.
- R9: If dma_req_i drops while the block waits for the grant, the grant still raises hold_ack for one cycle, and the release pulse follows at once.
- R10: Whenever rqgt_oe is 1 the driven level rqgt_out is 0. Whenever rqgt_oe is 0, rqgt_out rests at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| dma_req_i | input | 1 | Bus request from the DMA controller, active high |
| rqgt_in | input | 1 | Sampled level of the shared request/grant wire, active low |
| rqgt_out | output | 1 | Level driven onto the request/grant wire when enabled |
| rqgt_oe | output | 1 | Output enable for the request/grant wire |
| hold_ack | output | 1 | Bus granted to the DMA controller |
| dma_active | output | 1 | Handoff sequence in progress |

## Verification
The bench aims at the timing edges of the handshake. It tests a grant that arrives in the first listening cycle and one that arrives several cycles later. A design that counted the grant one edge early or late would show hold-acknowledge out of step with the model. Stray low pulses on the wire while idle or while holding are injected. A block that listened at the wrong time would grant itself the bus or release it. The bench also holds the request high through release and recovery, which catches a block that re-requests too early. It drops the request while a grant is outstanding, which catches a block that hangs waiting or never releases.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_WAIT    = 3'd2,
    ST_OWN     = 3'd3,
    ST_REL     = 3'd4,
    ST_RECOVER = 3'd5
  } arb_state_t;
endpackage

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm
  import dma_arb_pkg::*;
#(
  parameter int RECOVER_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dma_req_i,
  input  logic       grant_seen,
  output arb_state_t state
);
  localparam int RW = (RECOVER_CYCLES > 1) ? $clog2(RECOVER_CYCLES + 1) : 1;
  localparam logic [RW-1:0] RC_LOAD = RW'(RECOVER_CYCLES - 1);

  arb_state_t state_q, state_d;
  logic [RW-1:0] rc_q, rc_d;
  logic          rc_en;

  always_comb begin
    state_d = state_q;
    rc_d    = rc_q;
    rc_en   = 1'b0;
    unique case (state_q)
      ST_IDLE:    if (dma_req_i) state_d = ST_REQ;
      ST_REQ:     state_d = ST_WAIT;
      ST_WAIT:    if (grant_seen) state_d = ST_OWN;
      ST_OWN:     if (!dma_req_i) state_d = ST_REL;
      ST_REL: begin
        state_d = ST_RECOVER;
        rc_d    = RC_LOAD;
        rc_en   = 1'b1;
      end
      ST_RECOVER: begin
        if (rc_q == '0) begin
          state_d = ST_IDLE;
        end else begin
          rc_d  = rc_q - 1'b1;
          rc_en = 1'b1;
        end
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q <= '0;
    end else if (rc_en) begin
      rc_q <= rc_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/dma_arb_outdec.sv
module dma_arb_outdec
  import dma_arb_pkg::*;
(
  input  arb_state_t state,
  output logic       line_oe,
  output logic       line_lvl,
  output logic       hold,
  output logic       busy
);
  always_comb begin
    line_oe  = (state == ST_REQ) || (state == ST_REL);
    line_lvl = !line_oe;
    hold     = (state == ST_OWN);
    busy     = (state != ST_IDLE);
  end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int RECOVER_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_req_i,
  input  logic rqgt_in,
  output logic rqgt_out,
  output logic rqgt_oe,
  output logic hold_ack,
  output logic dma_active
);
  arb_state_t state;
  logic       grant_seen;

  // Grant is an active-low pulse from the processor; only heeded while listening.
  assign grant_seen = !rqgt_in;

  dma_arb_fsm #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_req_i  (dma_req_i),
    .grant_seen (grant_seen),
    .state      (state)
  );

  dma_arb_outdec u_dec (
    .state    (state),
    .line_oe  (rqgt_oe),
    .line_lvl (rqgt_out),
    .hold     (hold_ack),
    .busy     (dma_active)
  );
endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic dma_req_i,
  input logic rqgt_in,
  input logic rqgt_out,
  input logic rqgt_oe,
  input logic hold_ack,
  input logic dma_active
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_active |-> (!rqgt_oe && !hold_ack)); // R1

  AST_REQ_NEEDS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    (rqgt_oe && !$past(dma_active)) |-> $past(dma_req_i)); // R2

  AST_PULSE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    rqgt_oe |=> !rqgt_oe); // R2

  AST_HOLD_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> (!$past(rqgt_in) && !$past(rqgt_oe))); // R3

  AST_HOLD_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack) |-> rqgt_oe); // R5

  AST_HOLD_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> dma_active); // R8

  AST_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rqgt_oe |-> !rqgt_out); // R10

  AST_REST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !rqgt_oe |-> rqgt_out); // R10
endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dma_req_i  (dma_req_i),
  .rqgt_in    (rqgt_in),
  .rqgt_out   (rqgt_out),
  .rqgt_oe    (rqgt_oe),
  .hold_ack   (hold_ack),
  .dma_active (dma_active)
);

// File: tb/dma_bus_arbiter_test.sv
`timescale 1ns/1ps
module dma_bus_arbiter_test;
  localparam int RECOV = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic dma_req;
  logic rqgt_in;
  logic rqgt_out, rqgt_oe, hold_ack, dma_active;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  dma_bus_arbiter #(.RECOVER_CYCLES(RECOV)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_req_i  (dma_req),
    .rqgt_in    (rqgt_in),
    .rqgt_out   (rqgt_out),
    .rqgt_oe    (rqgt_oe),
    .hold_ack   (hold_ack),
    .dma_active (dma_active)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Processor side of the wire: answers request pulses, plus injected strays.
  int  gnt_delay = 0;
  bit  gnt_enable = 1'b1;
  bit  gnt_pending = 1'b0;
  int  gnt_wait = 0;
  int  pulse_cnt = 0;
  bit  stray = 1'b0;
  bit  grant_now = 1'b0;

  always_comb rqgt_in = !(grant_now || stray);

  always @(negedge clk) begin
    grant_now = 1'b0;
    if (gnt_pending) begin
      if (gnt_wait == 0) begin
        grant_now   = 1'b1;
        gnt_pending = 1'b0;
      end else begin
        gnt_wait--;
      end
    end
    if (!rst_n) begin
      pulse_cnt   = 0;
      gnt_pending = 1'b0;
      grant_now   = 1'b0;
    end else if (rqgt_oe && !rqgt_out) begin
      pulse_cnt++;
      if ((pulse_cnt % 2 == 1) && gnt_enable) begin
        gnt_pending = 1'b1;
        gnt_wait    = gnt_delay;
      end
    end
  end

  // Behavioural reference: position in the handoff sequence.
  int ph;       // 0 idle,1 ask,2 listen,3 owned,4 give back,5 settle
  int settle;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 0; settle <= 0;
    end else begin
      if (ph == 0 && dma_req) ph <= 1;
      else if (ph == 1) ph <= 2;
      else if (ph == 2 && !rqgt_in) ph <= 3;
      else if (ph == 3 && !dma_req) ph <= 4;
      else if (ph == 4) begin ph <= 5; settle <= RECOV; end
      else if (ph == 5) begin
        if (settle <= 1) ph <= 0;
        else settle <= settle - 1;
      end
    end
  end

  bit cmp_on = 1'b0;
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      automatic bit e_oe  = (ph == 1 || ph == 4);
      automatic bit e_hd  = (ph == 3);
      automatic bit e_act = (ph != 0);
      chk(rqgt_oe == e_oe, "R2 rqgt_oe", rqgt_oe, e_oe);
      chk(rqgt_out == !e_oe, "R10 rqgt_out", rqgt_out, !e_oe);
      chk(hold_ack == e_hd, "R3 hold_ack", hold_ack, e_hd);
      chk(dma_active == e_act, "R8 dma_active", dma_active, e_act);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_hold(input string tag);
    for (int i = 0; i < 40; i++) begin
      if (hold_ack) return;
      @(negedge clk);
    end
    chk(1'b0, tag, 0, 1);
  endtask

  initial begin
    rst_n = 1'b0; dma_req = 1'b0;
    step(3);
    // R1: reset state
    chk(rqgt_oe == 0 && rqgt_out == 1, "R1 line undriven in reset", rqgt_oe, 0);
    chk(hold_ack == 0 && dma_active == 0, "R1 hold/active low in reset", hold_ack, 0);
    rst_n = 1'b1; cmp_on = 1'b1;
    step(2);
    chk(!rqgt_oe && !dma_active, "R1 idle after reset", dma_active, 0);

    // R4: stray low on the wire while idle
    stray = 1'b1; step(1); stray = 1'b0; step(1);
    chk(!hold_ack && !dma_active, "R4 stray in idle ignored", hold_ack, 0);

    // R2/R3: grant in the first listening cycle
    gnt_delay = 0; dma_req = 1'b1;
    step(1);
    chk(rqgt_oe && !rqgt_out, "R2 request pulse driven", rqgt_oe, 1);
    step(1);
    chk(!rqgt_oe, "R2 pulse lasts one cycle", rqgt_oe, 0);
    step(1);
    chk(hold_ack, "R3 hold after immediate grant", hold_ack, 1);

    // R4: stray while holding
    stray = 1'b1; step(1); stray = 1'b0; step(1);
    chk(hold_ack && !rqgt_oe, "R4 stray while holding ignored", hold_ack, 1);

    // R5/R6: release
    dma_req = 1'b0; step(1);
    chk(rqgt_oe && !hold_ack, "R5 release pulse with hold low", rqgt_oe, 1);
    step(1);
    chk(!rqgt_oe && dma_active, "R6 recovery undriven and active", dma_active, 1);
    step(1);
    chk(!dma_active, "R6 idle after recovery", dma_active, 0);

    // R3: late grant
    gnt_delay = 4; dma_req = 1'b1;
    step(4);
    chk(!hold_ack, "R3 no hold before grant", hold_ack, 1'b0);
    wait_hold("R3 late grant reaches hold");
    step(3);

    // R7: request held through release and recovery
    dma_req = 1'b0; step(1);
    dma_req = 1'b1;
    chk(rqgt_oe, "R7 release pulse", rqgt_oe, 1);
    step(1);
    chk(!rqgt_oe, "R7 no pulse in recovery", rqgt_oe, 0);
    step(1);
    chk(!rqgt_oe && !dma_active, "R7 idle cycle before re-request", dma_active, 0);
    step(1);
    chk(rqgt_oe && dma_active, "R7 re-request after idle", rqgt_oe, 1);

    // R9: request dropped while waiting for grant
    gnt_delay = 3;
    step(1); dma_req = 1'b0;
    wait_hold("R9 grant still honoured");
    step(1);
    chk(!hold_ack && rqgt_oe, "R9 immediate release", rqgt_oe, 1);
    step(3);

    // Reset during ownership
    gnt_delay = 0; dma_req = 1'b1;
    wait_hold("R3 hold before reset");
    rst_n = 1'b0; #1;
    chk(!hold_ack && !rqgt_oe && !dma_active, "R1 async reset clears", hold_ack, 0);
    step(2); dma_req = 1'b0; rst_n = 1'b1;
    step(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule